// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block supervises a multi-rail power supply. It receives digitized over-voltage and under-voltage comparator flags for each rail. It also takes one extra over-voltage flag, a power-input-present flag and an active-high remote off request. From these it drives two outputs. The first is a latched shutdown signal for the PWM stage. The second is a power-good indication for the host. Every delay is a number of clock cycles set by a parameter, and every flag input passes through a two-flop synchronizer before any logic sees it.

The over-voltage sources are ORed together, and an over-voltage must persist for a confirmation delay before it trips the latch. The under-voltage sources are ORed together, and a missing power input counts as one of them. An under-voltage trips the latch at once, except inside a blanking window that opens at reset and opens again each time the remote request lets the supply back on. The remote input is filtered in both directions. Once it is accepted as active, it forces shutdown, drops power-good and clears the fault latch. Power-good rises only after every condition has been clean for a set delay, and it falls in the same cycle that a problem is seen.

Top module: `pss_supervisor`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fault_o` is 0 and `pgood_o` is 0.
- R2: Any `ov_flags` bit or `ov_extra` held high for OV_DLY consecutive synchronized cycles sets the fault latch. A run of OV_DLY-1 cycles leaves it clear.
- R3: Outside the blanking window, any `uv_flags` bit high or `pwr_in_ok` low sets the fault latch on the next clock after the synchronized flag is seen.
- R4: Under-voltage is ignored for BLANK_CYC cycles after reset.
- R5: Once set, the fault latch holds `fault_o` at 1 after every fault flag has cleared, until the remote input clears it.
- R6: The filtered remote state changes only after the synchronized `remote_off` has differed from it for REM_DLY consecutive cycles, in either direction. Shorter pulses have no effect.
- R7: While the filtered remote state is active, `fault_o` is 1, `pgood_o` is 0 and the fault latch is cleared.
- R8: `pgood_o` rises after PG_DLY consecutive cycles with no fault condition, no latched fault and no remote off. It falls in the first cycle such a condition is seen after synchronization.
- R9: When the filtered remote state returns to inactive, a fresh blanking window of BLANK_CYC cycles starts.
- R10: Every flag input passes through two synchronizer flops, so a change at an input reaches the control logic two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ov_flags | input | N_RAILS | Per-rail over-voltage flags, 1 = over |
| uv_flags | input | N_RAILS | Per-rail under-voltage flags, 1 = under |
| ov_extra | input | 1 | Extra over-voltage flag, 1 = over |
| pwr_in_ok | input | 1 | Power input present, 0 = treated as under-voltage |
| remote_off | input | 1 | Remote request, 1 = supply off |
| fault_o | output | 1 | 1 = shut the supply down |
| pgood_o | output | 1 | 1 = all conditions good |

## Verification
The bench builds the block with three rails, BLANK_CYC = 20, OV_DLY = 6, PG_DLY = 10 and REM_DLY = 8. With these short windows it can place runs one cycle below and exactly at each threshold. It can also land an under-voltage pulse inside both the reset blanking window and the window that opens after a remote release. A remote release, a clean power-good delay and a fresh trip all fit in a few hundred cycles, so every latch-set and latch-clear path runs several times against the per-cycle model.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef struct packed {
        logic ov;
        logic uv;
    } pss_cond_t;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pss_sat_counter.sv
module pss_sat_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    import pss_pkg::*;
    localparam int W = cnt_bits(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != W'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == W'(LIMIT));
endmodule

// File: rtl/pss_remote_filter.sv
module pss_remote_filter #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic state
);
    import pss_pkg::*;
    localparam int W = cnt_bits(DLY);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
            cnt   <= '0;
        end else if (raw == state) begin
            cnt <= '0;
        end else if (cnt == W'(DLY - 1)) begin
            state <= raw;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pss_supervisor.sv
module pss_supervisor #(
    parameter int N_RAILS   = 3,
    parameter int BLANK_CYC = 20,
    parameter int OV_DLY    = 6,
    parameter int PG_DLY    = 10,
    parameter int REM_DLY   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] ov_flags,
    input  logic [N_RAILS-1:0] uv_flags,
    input  logic               ov_extra,
    input  logic               pwr_in_ok,
    input  logic               remote_off,
    output logic               fault_o,
    output logic               pgood_o
);
    import pss_pkg::*;

    localparam int SW      = 2 * N_RAILS + 3;
    localparam int I_EXTRA = 2 * N_RAILS;
    localparam int I_PWR   = 2 * N_RAILS + 1;
    localparam int I_REM   = 2 * N_RAILS + 2;

    logic [SW-1:0] raw_vec, sync_vec;
    pss_cond_t     cond;
    logic          rem_sync, rem_state;
    logic          blank_done, blanking;
    logic          ov_done, ov_trip;
    logic          latch;
    logic          cond_ok, pg_done;

    assign raw_vec = {remote_off, pwr_in_ok, ov_extra, uv_flags, ov_flags};

    pss_sync #(.WIDTH(SW)) u_sync (
        .clk(clk), .rst(rst), .d(raw_vec), .q(sync_vec)
    );

    assign cond.ov  = (|sync_vec[N_RAILS-1:0]) | sync_vec[I_EXTRA];
    assign cond.uv  = (|sync_vec[2*N_RAILS-1:N_RAILS]) | ~sync_vec[I_PWR];
    assign rem_sync = sync_vec[I_REM];

    pss_remote_filter #(.DLY(REM_DLY)) u_rem (
        .clk(clk), .rst(rst), .raw(rem_sync), .state(rem_state)
    );

    // blanking window restarts while remote holds the supply off
    pss_sat_counter #(.LIMIT(BLANK_CYC)) u_blank (
        .clk(clk), .rst(rst), .clr(rem_state), .done(blank_done)
    );
    assign blanking = ~blank_done;

    // over-voltage confirmation: counts consecutive cycles
    pss_sat_counter #(.LIMIT(OV_DLY - 1)) u_ovq (
        .clk(clk), .rst(rst), .clr(~cond.ov), .done(ov_done)
    );
    assign ov_trip = cond.ov & ov_done;

    always_ff @(posedge clk) begin
        if (rst || rem_state)
            latch <= 1'b0;
        else if (ov_trip || (cond.uv && !blanking))
            latch <= 1'b1;
    end

    assign cond_ok = ~cond.ov & ~cond.uv & ~latch & ~rem_state;

    pss_sat_counter #(.LIMIT(PG_DLY)) u_pg (
        .clk(clk), .rst(rst), .clr(~cond_ok), .done(pg_done)
    );

    assign fault_o = latch | rem_state;
    assign pgood_o = cond_ok & pg_done;
endmodule

// File: rtl/pss_supervisor_chk.sv
module pss_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic fault_o,
    input logic pgood_o,
    input logic latch,
    input logic rem_state,
    input logic rem_sync,
    input logic blanking,
    input logic uv_any,
    input logic ov_any
);
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (latch && !rem_state) |=> latch);

    p_remote_forces_r7: assert property (@(posedge clk) disable iff (rst)
        rem_state |-> (fault_o && !pgood_o));

    p_latch_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(latch) |-> $past(rem_state));

    p_uv_trip_r3: assert property (@(posedge clk) disable iff (rst)
        (!rem_state && !blanking && uv_any) |=> latch);

    p_rem_filter_r6: assert property (@(posedge clk) disable iff (rst)
        (rem_state != $past(rem_state)) |-> (rem_sync == rem_state));

    p_pg_clean_r8: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> (!ov_any && !uv_any && !fault_o));
endmodule

bind pss_supervisor pss_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .fault_o(fault_o), .pgood_o(pgood_o),
    .latch(latch), .rem_state(rem_state), .rem_sync(rem_sync),
    .blanking(blanking), .uv_any(cond.uv), .ov_any(cond.ov)
);

// File: tb/pss_supervisor_bench.sv
module pss_supervisor_bench;
    localparam int NR = 3, BL = 20, OVD = 6, PGD = 10, RMD = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic [NR-1:0] ov_flags = '0, uv_flags = '0;
    logic ov_extra = 1'b0, pwr_in_ok = 1'b1, remote_off = 1'b0;
    logic fault_o, pgood_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pss_supervisor #(.N_RAILS(NR), .BLANK_CYC(BL), .OV_DLY(OVD),
                     .PG_DLY(PGD), .REM_DLY(RMD)) u_pss_supervisor (
        .clk(clk), .rst(rst), .ov_flags(ov_flags), .uv_flags(uv_flags),
        .ov_extra(ov_extra), .pwr_in_ok(pwr_in_ok), .remote_off(remote_off),
        .fault_o(fault_o), .pgood_o(pgood_o));

    // reference model: input samples queued through two-stage delay (R10)
    typedef struct { bit ov; bit uv; bit rem; } smp_t;
    smp_t q[$];
    int m_rem, m_rcnt, m_blank, m_ovrun, m_latch, m_pgrun;

    function automatic smp_t now_smp();
        smp_t s;
        s.ov  = (|ov_flags) || ov_extra;
        s.uv  = (|uv_flags) || !pwr_in_ok;
        s.rem = remote_off;
        return s;
    endfunction

    function automatic bit m_ok();
        return !q[0].ov && !q[0].uv && m_latch == 0 && m_rem == 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            smp_t z;
            z.ov = 0; z.uv = 0; z.rem = 0;
            q = {};
            q.push_back(z); q.push_back(z);
            m_rem = 0; m_rcnt = 0; m_blank = 0; m_ovrun = 0; m_latch = 0; m_pgrun = 0;
        end else begin
            smp_t c;
            int o_rem, o_latch;
            bit ok, blank_on;
            c = q[0];
            o_rem = m_rem; o_latch = m_latch;
            ok = m_ok();
            blank_on = (m_blank < BL);
            // remote filter
            if (int'(c.rem) == o_rem) m_rcnt = 0;
            else if (m_rcnt == RMD - 1) begin m_rem = c.rem; m_rcnt = 0; end
            else m_rcnt++;
            // latch
            if (o_rem != 0) m_latch = 0;
            else if ((c.ov && m_ovrun >= OVD - 1) || (c.uv && !blank_on)) m_latch = 1;
            // over-voltage run length
            m_ovrun = c.ov ? m_ovrun + 1 : 0;
            // blanking counter
            if (o_rem != 0) m_blank = 0; else if (m_blank < BL) m_blank++;
            // power-good run length
            if (!ok) m_pgrun = 0; else if (m_pgrun < PGD) m_pgrun++;
            void'(q.pop_front());
            q.push_back(now_smp());
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model (R10 timing, R5, R7, R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5/R7 model fault", fault_o, logic'(m_latch != 0 || m_rem != 0));
            chk("R8 model pgood", pgood_o, logic'(m_ok() && m_pgrun >= PGD));
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ov(int n, int rail);
        if (rail < 0) ov_extra = 1'b1; else ov_flags[rail] = 1'b1;
        wait_n(n);
        ov_extra = 1'b0; ov_flags = '0;
    endtask

    task automatic clear_fault();
        remote_off = 1'b1;
        wait_n(RMD + 4);
        chk("R7 remote active fault", fault_o, 1'b1);
        chk("R7 remote active pgood", pgood_o, 1'b0);
        remote_off = 1'b0;
        wait_n(4);
        chk("R6 release filtered", fault_o, 1'b1);
        wait_n(RMD + 2);
        chk("R7 latch cleared", fault_o, 1'b0);
        wait_n(BL + PGD + 4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        wait_n(3);
        chk("R1 reset fault", fault_o, 1'b0);
        chk("R1 reset pgood", pgood_o, 1'b0);
        rst = 1'b0;
        wait_n(1);
        chk("R1 after reset fault", fault_o, 1'b0);
        // R4: under-voltage inside the reset blanking window
        uv_flags[1] = 1'b1;
        wait_n(5);
        uv_flags = '0;
        wait_n(6);
        chk("R4 blanked uv", fault_o, 1'b0);
        wait_n(BL + PGD + 5);
        chk("R8 pgood up", pgood_o, 1'b1);
        // R2 short over-voltage; R8 immediate fall and delayed rise
        pulse_ov(OVD - 1, 0);
        chk("R8 pgood falls", pgood_o, 1'b0);
        wait_n(8);
        chk("R2 short ov ignored", fault_o, 1'b0);
        chk("R8 pgood waits", pgood_o, 1'b0);
        wait_n(PGD);
        chk("R8 pgood back", pgood_o, 1'b1);
        // R2 full-length over-voltage trips
        pulse_ov(OVD, 2);
        wait_n(4);
        chk("R2 ov trips", fault_o, 1'b1);
        wait_n(10);
        chk("R5 latch holds", fault_o, 1'b1);
        chk("R5 pgood low", pgood_o, 1'b0);
        // R6 short remote pulse leaves latch
        remote_off = 1'b1;
        wait_n(RMD - 1);
        remote_off = 1'b0;
        wait_n(12);
        chk("R6 short remote ignored", fault_o, 1'b1);
        // R7 long pulse clears; R9 fresh blanking after release
        remote_off = 1'b1;
        wait_n(RMD + 4);
        chk("R7 remote fault", fault_o, 1'b1);
        remote_off = 1'b0;
        wait_n(RMD + 2);
        chk("R7 cleared", fault_o, 1'b0);
        uv_flags[0] = 1'b1;
        wait_n(4);
        uv_flags = '0;
        wait_n(6);
        chk("R9 reblanked uv", fault_o, 1'b0);
        wait_n(BL + PGD + 4);
        chk("R9 pgood after restart", pgood_o, 1'b1);
        // R6 short remote pulse with no latch does not raise fault
        remote_off = 1'b1;
        wait_n(RMD - 1);
        remote_off = 1'b0;
        wait_n(3);
        chk("R6 short remote no fault", fault_o, 1'b0);
        wait_n(PGD + 4);
        // R3 power input missing for one cycle, after blanking
        pwr_in_ok = 1'b0;
        wait_n(1);
        pwr_in_ok = 1'b1;
        wait_n(3);
        chk("R3 pwr_in trips", fault_o, 1'b1);
        clear_fault();
        // R2 extra over-voltage
        pulse_ov(OVD, -1);
        wait_n(4);
        chk("R2 extra ov trips", fault_o, 1'b1);
        clear_fault();
        // R3 rail under-voltage
        uv_flags[2] = 1'b1;
        wait_n(1);
        uv_flags = '0;
        wait_n(3);
        chk("R3 rail uv trips", fault_o, 1'b1);
        clear_fault();
        chk("R8 final pgood", pgood_o, 1'b1);
        finish_run();
    end

    initial begin
        wait (cyc > 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule